// File: doc/BRIEF.md
# Block DMA Engine

This block is one channel of a byte-wide block mover. It copies bytes between a 24-bit address on the wide memory bus (the A side) and a small window of 256 peripheral registers (the B side). Before a transfer, software-visible setup logic presents a control byte, a base register number, a starting A address and a byte count, and then pulses `start`. The engine then performs one access per fixed-length slot until the count runs out.

On the B side, the register number follows a short repeating pattern chosen by a 3-bit mode. This lets a single transfer feed pairs or quads of neighbouring registers. The byte count is a hard limit and can stop a pattern part-way through. On the A side, only the low 16 address bits step, so a transfer never leaves its bank.

An outside arbiter can stall the channel with `pause` or end it with `abort`. The address and count outputs always show the live working values, so the point where a transfer stopped can be read back.

Top module: `dma_block_engine`

## Requirements
- R1: After reset, `busy`, `done` and all four strobes are low. A `start` pulse while idle latches all setup inputs and raises `busy` at that clock edge. A `start` pulse while `busy` is high has no effect.
- R2: The B register driven on access k is `port` plus an offset taken from the mode in control bits [2:0]:
  - mode 0: always 0
  - mode 1: 0,1
  - modes 2 and 6: 0,0
  - modes 3 and 7: 0,0,1,1
  - mode 4: 0,1,2,3
  - mode 5: 0,1,0,1
- R3: The offset pattern restarts after its last element, and the transfer stops after exactly `count` bytes even mid-pattern. For example, count 5 in mode 4 gives offsets 0,1,2,3,0.
- R4: After each access, the A address behaves as follows:
  - It is held if control bit 3 is set.
  - Otherwise it steps down by one if control bit 4 is set, and up by one if not.
  - Only bits [15:0] change, wrapping within 16 bits; bits [23:16] never change.
- R5: The count drops by one after every access and is tested after the drop. Reaching zero ends the transfer with a one-cycle `done` pulse and `busy` low. A starting count of 0 therefore means 65536 bytes.
- R6: With control bit 7 clear, each access asserts `a_rd` and `b_wr` together. With bit 7 set, each access asserts `b_rd` and `a_wr` together.
- R7: One access happens every SLOT_CYCLES clock cycles (default 8). The first access falls in the SLOT_CYCLES-th cycle after the accepting edge.
- R8: While `abort` is high during a transfer, no strobe is asserted, `busy` falls at the next edge, `done` stays low, and the address and count keep their current values.
- R9: While `pause` is high, no strobe is asserted and the address, count, pattern position and slot timing all hold. When `pause` drops, the transfer resumes from the held slot position.
- R10: The B register number is 8 bits wide and wraps from 0xFF to 0x00 when the offset is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| ctrl_in | input | 8 | [7] direction, [4] step down, [3] hold address, [2:0] mode |
| port_in | input | 8 | Base B register number |
| addr_in | input | 24 | Starting A address |
| count_in | input | 16 | Byte count, 0 means 65536 |
| pause | input | 1 | Stall the transfer |
| abort | input | 1 | End the transfer without completing it |
| a_addr | output | 24 | Current A address |
| b_port | output | 8 | Current B register number |
| a_rd | output | 1 | Read strobe on the A side |
| a_wr | output | 1 | Write strobe on the A side |
| b_rd | output | 1 | Read strobe on the B side |
| b_wr | output | 1 | Write strobe on the B side |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| count_out | output | 16 | Remaining byte count |

## Verification
The critical coincidences are `pause` and `abort` landing in the exact cycle when a slot would perform its access. The bench drives each of them just after the edge that opens an access cycle.

For pause, it expects the strobe to be withheld and then to appear in the first cycle after release, with later accesses shifted by the pause length. For abort, it uses a zero starting count and expects three accesses, a count of 0xFFFD, an address three steps on, and no `done` pulse.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef struct packed {
        logic       to_a;     // 1: B side read, A side write
        logic       step_dn;  // 1: address steps down
        logic       hold;     // 1: address held
        logic [2:0] mode;
    } xfer_cfg_t;

    function automatic xfer_cfg_t unpack_ctrl(input logic [7:0] c);
        xfer_cfg_t r;
        r.to_a    = c[7];
        r.step_dn = c[4];
        r.hold    = c[3];
        r.mode    = c[2:0];
        return r;
    endfunction

    // index of the final element of the offset pattern
    function automatic logic [1:0] pattern_end(input logic [2:0] m);
        case (m)
            3'd0:                   return 2'd0;
            3'd1, 3'd2, 3'd6:       return 2'd1;
            default:                return 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] pattern_offset(input logic [2:0] m, input logic [1:0] k);
        case (m)
            3'd0, 3'd2, 3'd6: return 2'd0;
            3'd1, 3'd5:       return {1'b0, k[0]};
            3'd3, 3'd7:       return {1'b0, k[1]};
            default:          return k;
        endcase
    endfunction

endpackage

// File: rtl/dma_slot_timer.sv
module dma_slot_timer #(
    parameter int SLOT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] phase;

    assign tick = run && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            phase <= '0;
        else if (run)
            phase <= tick ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/dma_port_seq.sv
module dma_port_seq
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       step,
    input  logic [2:0] mode,
    input  logic [7:0] base,
    output logic [7:0] reg_no
);
    logic [1:0] pos;

    assign reg_no = base + {6'd0, pattern_offset(mode, pos)};

    always_ff @(posedge clk) begin
        if (rst || load)
            pos <= 2'd0;
        else if (step)
            pos <= (pos == pattern_end(mode)) ? 2'd0 : pos + 2'd1;
    end
endmodule

// File: rtl/dma_addr_count.sv
module dma_addr_count #(
    parameter int AW = 24,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic            hold,
    input  logic            step_dn,
    input  logic [AW-1:0]   addr_in,
    input  logic [CNTW-1:0] count_in,
    output logic [AW-1:0]   addr,
    output logic [CNTW-1:0] count,
    output logic            last_byte
);
    localparam int LOW = 16;

    logic [LOW-1:0] low_next;

    assign last_byte = (count == CNTW'(1));

    always_comb begin
        low_next = addr[LOW-1:0];
        if (!hold)
            low_next = step_dn ? addr[LOW-1:0] - 1'b1 : addr[LOW-1:0] + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            count <= '0;
        end else if (load) begin
            addr  <= addr_in;
            count <= count_in;
        end else if (step) begin
            addr  <= {addr[AW-1:LOW], low_next};
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/dma_block_engine.sv
module dma_block_engine
    import dma_pkg::*;
#(
    parameter int SLOT_CYCLES = 8,
    parameter int AW = 24,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [7:0]      ctrl_in,
    input  logic [7:0]      port_in,
    input  logic [AW-1:0]   addr_in,
    input  logic [CNTW-1:0] count_in,
    input  logic            pause,
    input  logic            abort,
    output logic [AW-1:0]   a_addr,
    output logic [7:0]      b_port,
    output logic            a_rd,
    output logic            a_wr,
    output logic            b_rd,
    output logic            b_wr,
    output logic            busy,
    output logic            done,
    output logic [CNTW-1:0] count_out
);
    xfer_cfg_t  cfg;
    logic [7:0] port_base;
    logic       accept, run, access, last_byte, finish;
    logic       unused_ctrl;

    assign unused_ctrl = ^ctrl_in[6:5];
    assign accept = start && !busy;
    assign run    = busy && !pause && !abort;
    assign finish = access && last_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            cfg       <= '0;
            port_base <= '0;
        end else begin
            done <= finish;
            if (accept) begin
                busy      <= 1'b1;
                cfg       <= unpack_ctrl(ctrl_in);
                port_base <= port_in;
            end else if (busy && (abort || finish)) begin
                busy <= 1'b0;
            end
        end
    end

    dma_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) i_timer (
        .clk(clk), .rst(rst), .restart(accept), .run(run), .tick(access)
    );

    dma_port_seq i_seq (
        .clk(clk), .rst(rst), .load(accept), .step(access),
        .mode(cfg.mode), .base(port_base), .reg_no(b_port)
    );

    dma_addr_count #(.AW(AW), .CNTW(CNTW)) i_ac (
        .clk(clk), .rst(rst), .load(accept), .step(access),
        .hold(cfg.hold), .step_dn(cfg.step_dn),
        .addr_in(addr_in), .count_in(count_in),
        .addr(a_addr), .count(count_out), .last_byte(last_byte)
    );

    assign a_rd = access && !cfg.to_a;
    assign b_wr = access && !cfg.to_a;
    assign b_rd = access &&  cfg.to_a;
    assign a_wr = access &&  cfg.to_a;

    a_r4_bank_fixed: assert property (@(posedge clk) disable iff (rst)
        busy |=> (a_addr[AW-1:16] == $past(a_addr[AW-1:16])));

    a_r5_count_drop: assert property (@(posedge clk) disable iff (rst)
        (a_rd || b_rd) |=> (count_out == $past(count_out) - 1'b1));

    a_r5_done_at_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> (count_out == '0 && !busy));

    a_r8_abort_stops: assert property (@(posedge clk) disable iff (rst)
        (abort && busy) |=> (!busy && !done && $stable(count_out) && $stable(a_addr)));

    a_r9_pause_holds: assert property (@(posedge clk) disable iff (rst)
        (pause && busy) |=> ($stable(count_out) && $stable(a_addr)));

    a_r6_one_side_reads: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_rd, b_rd}));
endmodule

// File: tb/test_dma_block_engine.sv
module test_dma_block_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, pause = 1'b0, abort = 1'b0;
    logic [7:0]  ctrl_in = '0, port_in = '0;
    logic [23:0] addr_in = '0;
    logic [15:0] count_in = '0;
    logic [23:0] a_addr;
    logic [7:0]  b_port;
    logic        a_rd, a_wr, b_rd, b_wr, busy, done;
    logic [15:0] count_out;

    int checks = 0, fails = 0;
    int cyc = 0;
    int log_n = 0;
    int done_n = 0;
    logic [7:0]  log_port [256];
    logic [23:0] log_addr [256];
    int          log_cyc  [256];
    logic [3:0]  log_strb [256];
    bit          finished = 0;

    always #10 clk = ~clk;

    dma_block_engine i_dma_block_engine (
        .clk(clk), .rst(rst), .start(start), .ctrl_in(ctrl_in), .port_in(port_in),
        .addr_in(addr_in), .count_in(count_in), .pause(pause), .abort(abort),
        .a_addr(a_addr), .b_port(b_port), .a_rd(a_rd), .a_wr(a_wr),
        .b_rd(b_rd), .b_wr(b_wr), .busy(busy), .done(done), .count_out(count_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (a_rd | a_wr | b_rd | b_wr) begin
            log_port[log_n % 256] <= b_port;
            log_addr[log_n % 256] <= a_addr;
            log_cyc[log_n % 256]  <= cyc;
            log_strb[log_n % 256] <= {a_rd, a_wr, b_rd, b_wr};
            log_n <= log_n + 1;
        end
        if (done) done_n <= done_n + 1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic launch(input logic [7:0] c, input logic [7:0] p, input logic [23:0] a,
                          input logic [15:0] n, output int c0, output int base);
        @(posedge clk); #1;
        ctrl_in = c; port_in = p; addr_in = a; count_in = n; start = 1'b1;
        base = log_n;
        @(posedge clk); #1;
        start = 1'b0;
        c0 = cyc;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) begin
            @(posedge clk); #1;
        end
        tick_n(2);
    endtask

    task automatic check_ports(input int base, input int n, input logic [7:0] exp [8], input string req);
        check(log_n - base == n, {req, " access count"}, log_n - base, n);
        for (int i = 0; i < n && i < 8; i++)
            check(log_port[(base + i) % 256] == exp[i], req, log_port[(base + i) % 256], exp[i]);
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
        check({a_rd, a_wr, b_rd, b_wr} == 0, "R1 reset strobes", {a_rd, a_wr, b_rd, b_wr}, 0);
    endtask

    task automatic t_quad_up();
        int c0, base, d0;
        d0 = done_n;
        launch(8'h04, 8'h10, 24'h12FFFE, 16'd5, c0, base);
        check(busy == 1, "R1 busy after start", busy, 1);
        wait_idle();
        check_ports(base, 5, '{8'h10, 8'h11, 8'h12, 8'h13, 8'h10, 0, 0, 0}, "R2 R3 mode4 count5");
        check(log_addr[(base + 1) % 256] == 24'h12FFFF, "R4 step up", log_addr[(base + 1) % 256], 24'h12FFFF);
        check(log_addr[(base + 2) % 256] == 24'h120000, "R4 bank kept on wrap", log_addr[(base + 2) % 256], 24'h120000);
        check(a_addr == 24'h120003, "R4 final addr", a_addr, 24'h120003);
        check(log_strb[base % 256] == 4'b1001, "R6 A read B write", log_strb[base % 256], 4'b1001);
        check(log_cyc[base % 256] == c0 + 7, "R7 first access", log_cyc[base % 256], c0 + 7);
        check(log_cyc[(base + 4) % 256] - log_cyc[(base + 3) % 256] == 8, "R7 spacing",
              log_cyc[(base + 4) % 256] - log_cyc[(base + 3) % 256], 8);
        check(count_out == 0 && done_n == d0 + 1, "R5 count zero and one done", {count_out, 8'(done_n - d0)}, 1);
    endtask

    task automatic t_alt_down_wrap();
        int c0, base;
        launch(8'h95, 8'hFF, 24'h340001, 16'd6, c0, base);
        wait_idle();
        check_ports(base, 6, '{8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0}, "R2 R10 mode5 wrap");
        check(log_addr[(base + 2) % 256] == 24'h34FFFF, "R4 step down bank kept", log_addr[(base + 2) % 256], 24'h34FFFF);
        check(log_strb[base % 256] == 4'b0110, "R6 B read A write", log_strb[base % 256], 4'b0110);
    endtask

    task automatic t_modes_fixed();
        int c0, base;
        launch(8'h08, 8'h20, 24'h0A1234, 16'd4, c0, base); wait_idle();
        check_ports(base, 4, '{8'h20, 8'h20, 8'h20, 8'h20, 0, 0, 0, 0}, "R2 mode0");
        check(a_addr == 24'h0A1234 && log_addr[(base + 3) % 256] == 24'h0A1234, "R4 fixed hold", a_addr, 24'h0A1234);
        launch(8'h09, 8'h20, 24'h0A1234, 16'd4, c0, base); wait_idle();
        check_ports(base, 4, '{8'h20, 8'h21, 8'h20, 8'h21, 0, 0, 0, 0}, "R2 mode1");
        launch(8'h0A, 8'h20, 24'h0A1234, 16'd4, c0, base); wait_idle();
        check_ports(base, 4, '{8'h20, 8'h20, 8'h20, 8'h20, 0, 0, 0, 0}, "R2 mode2");
        launch(8'h0E, 8'h20, 24'h0A1234, 16'd3, c0, base); wait_idle();
        check_ports(base, 3, '{8'h20, 8'h20, 8'h20, 0, 0, 0, 0, 0}, "R2 mode6");
        launch(8'h0B, 8'h20, 24'h0A1234, 16'd6, c0, base); wait_idle();
        check_ports(base, 6, '{8'h20, 8'h20, 8'h21, 8'h21, 8'h20, 8'h20, 0, 0}, "R2 R3 mode3");
        launch(8'h0F, 8'h20, 24'h0A1234, 16'd4, c0, base); wait_idle();
        check_ports(base, 4, '{8'h20, 8'h20, 8'h21, 8'h21, 0, 0, 0, 0}, "R2 mode7");
        launch(8'h04, 8'h40, 24'h0A1234, 16'd1, c0, base); wait_idle();
        check_ports(base, 1, '{8'h40, 0, 0, 0, 0, 0, 0, 0}, "R3 count1 cuts mode4");
    endtask

    task automatic t_start_busy();
        int c0, base;
        launch(8'h00, 8'h30, 24'h000100, 16'd3, c0, base);
        tick_n(3);
        start = 1'b1; ctrl_in = 8'h04; port_in = 8'h77; count_in = 16'd9; addr_in = 24'hFF0000;
        tick_n(1);
        start = 1'b0;
        wait_idle();
        check_ports(base, 3, '{8'h30, 8'h30, 8'h30, 0, 0, 0, 0, 0}, "R1 start ignored while busy");
        check(a_addr == 24'h000103, "R1 address unaffected", a_addr, 24'h000103);
    endtask

    task automatic t_pause_on_access();
        int c0, base;
        launch(8'h00, 8'h50, 24'h000200, 16'd3, c0, base);
        while (cyc < c0 + 7) tick_n(1);
        pause = 1'b1;
        tick_n(5);
        check(log_n == base, "R9 no access while paused", log_n - base, 0);
        check(count_out == 16'd3 && a_addr == 24'h000200, "R9 state held", count_out, 3);
        pause = 1'b0;
        wait_idle();
        check(log_n - base == 3, "R9 resume count", log_n - base, 3);
        check(log_cyc[base % 256] == c0 + 12, "R9 resumed access cycle", log_cyc[base % 256], c0 + 12);
        check(log_cyc[(base + 1) % 256] == c0 + 20, "R9 later slot shifted", log_cyc[(base + 1) % 256], c0 + 20);
    endtask

    task automatic t_abort_on_access();
        int c0, base, d0;
        d0 = done_n;
        launch(8'h00, 8'h60, 24'h050000, 16'd0, c0, base);
        while (cyc < c0 + 31) tick_n(1);
        abort = 1'b1;
        tick_n(1);
        abort = 1'b0;
        tick_n(2);
        check(busy == 0, "R8 busy dropped", busy, 0);
        check(log_n - base == 3, "R8 access withheld", log_n - base, 3);
        check(count_out == 16'hFFFD, "R5 R8 zero count is 65536", count_out, 16'hFFFD);
        check(a_addr == 24'h050003, "R8 address kept", a_addr, 24'h050003);
        check(done_n == d0, "R8 no done", done_n - d0, 0);
    endtask

    initial begin
        tick_n(3);
        t_reset();
        rst = 1'b0;
        tick_n(2);
        t_quad_up();
        t_alt_down_wrap();
        t_modes_fixed();
        t_start_busy();
        t_pause_on_access();
        t_abort_on_access();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule